// File: doc/BRIEF.md
# Programmed-I/O Point-Plot Coordinate Interface

This block sits on the I/O bus of a 12-bit minicomputer and holds the beam position for a point-plotting display. It watches the buffered instruction word. When the opcode field carries the I/O-transfer code and the device field names one of its two devices, it reacts to the three sequential I/O pulses of that instruction. The first device owns the horizontal (X) coordinate and the second owns the vertical (Y) coordinate. Each coordinate is a 10-bit register that feeds a digital-to-analog converter downstream.

The three low operation bits of the instruction are independent micro-operations, and each one is tied to one pulse. The bit of value 1 clears the selected register on pulse 1. The bit of value 2 loads it from the accumulator on pulse 2. The bit of value 4 raises a one-cycle display request on pulse 3. The operations run in pulse order, so a single instruction can clear, load and then plot. The plot operation behaves the same from either device, which lets software position the last axis and plot with one instruction.

Bit numbering follows the host machine: bit 0 is the most significant bit of a 12-bit word, so bit k sits at vector index 11-k.

Top module: `iot_xy_plot`

## Requirements
- R1: While `rst_n` is low, `x_pos`, `y_pos` and `plot_req` are zero.
- R2: When `io_pulse1` is sampled high, the instruction is accepted (defined in R8), and operation bit 11 (`instr[0]`, value 1) is set, the selected register becomes zero on that clock edge. Device code octal 05 selects X and octal 06 selects Y.
- R3: When `io_pulse2` is sampled high, the instruction is accepted, and operation bit 10 (`instr[1]`, value 2) is set, the selected register takes accumulator bits 2..11 (`acc[9:0]`) on that clock edge.
- R4: When `io_pulse3` is sampled high, the instruction is accepted for either device code, and operation bit 9 (`instr[2]`, value 4) is set, `plot_req` is high for exactly the following cycle.
- R5: Each operation bit acts only on its own pulse, and a pulse does nothing when its bit is clear. For example, octal 6066 leaves Y unchanged on pulse 1, loads Y on pulse 2, and plots on pulse 3.
- R6: When clear and load for the same register are sampled on the same edge, the register becomes zero.
- R7: `bus_init` sampled high clears both registers and suppresses `plot_req` on that edge. It overrides any pulse.
- R8: An instruction is accepted only when bits 0..2 (`instr[11:9]`) equal octal 6 and the device field, bits 3..8 (`instr[8:3]`), equals octal 05 or octal 06. Any other instruction leaves both registers unchanged and raises no request.
- R9: An operation addressed to one device leaves the other device's register unchanged.
- R10: Accumulator bits 0 and 1 (`acc[11:10]`) have no effect on the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_init | input | 1 | Synchronous bus initialize, active high |
| instr | input | 12 | Buffered instruction word, index 11 = bit 0 |
| io_pulse1 | input | 1 | First I/O pulse, one-cycle strobe |
| io_pulse2 | input | 1 | Second I/O pulse, one-cycle strobe |
| io_pulse3 | input | 1 | Third I/O pulse, one-cycle strobe |
| acc | input | 12 | Accumulator data bus |
| x_pos | output | 10 | Horizontal coordinate |
| y_pos | output | 10 | Vertical coordinate |
| plot_req | output | 1 | One-cycle display-point request |

## Verification
Both coordinates are plain registers that drive the ports directly. A wrong clear, load or hold therefore shows on `x_pos` or `y_pos` in the cycle right after the pulse edge, and it stays visible until the next operation on that axis. A decode fault, such as a wrong device match, a wrong opcode match, or an operation bit bound to the wrong pulse, shows one cycle after the offending pulse. It appears either as an unexpected register change or as a missing or extra `plot_req`. The stimulus mixes random instructions, including foreign devices and opcodes, with directed combined, same-edge and initialize cases, so each pulse's result is compared in that following cycle.

// File: rtl/iot_xy_pkg.sv
package iot_xy_pkg;
  localparam int WORD_W  = 12;
  localparam int COORD_W = 10;
  localparam int DEV_W   = 6;
  localparam int DEV_LSB = 3;
  localparam int OPC_W   = 3;
  localparam logic [OPC_W-1:0] OPC_IOT = 3'o6;

  typedef struct packed {
    logic clr;
    logic ld;
    logic plot;
  } iot_ops_t;
endpackage

// File: rtl/iot_dev_decode.sv
module iot_dev_decode
  import iot_xy_pkg::*;
#(
  parameter logic [DEV_W-1:0] DEV_CODE = 6'o05
) (
  input  logic [WORD_W-1:0] instr,
  input  logic              io_pulse1,
  input  logic              io_pulse2,
  input  logic              io_pulse3,
  output logic              hit,
  output iot_ops_t          ops
);
  localparam int OPC_LSB = WORD_W - OPC_W;

  always_comb begin
    hit      = (instr[WORD_W-1:OPC_LSB] == OPC_IOT) &&
               (instr[DEV_LSB+DEV_W-1:DEV_LSB] == DEV_CODE);
    ops.clr  = hit && io_pulse1 && instr[0];
    ops.ld   = hit && io_pulse2 && instr[1];
    ops.plot = hit && io_pulse3 && instr[2];
  end
endmodule

// File: rtl/coord_reg.sv
module coord_reg #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic         en;
  logic [W-1:0] q_nxt;

  always_comb begin
    en    = init | clr | ld;
    q_nxt = q;
    if (init || clr) q_nxt = '0;
    else if (ld)     q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= q_nxt;
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(init || clr || ld) |=> $stable(q));
  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !init) |=> (q == '0));
  assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && ld) |=> (q == '0));
  assert_init_R7: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (q == '0));
endmodule

// File: rtl/plot_strobe.sv
module plot_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic fire,
  output logic req
);
  logic req_nxt;

  always_comb req_nxt = fire & ~init;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= 1'b0;
    else        req <= req_nxt;
  end
endmodule

// File: rtl/iot_xy_plot.sv
module iot_xy_plot
  import iot_xy_pkg::*;
#(
  parameter logic [DEV_W-1:0] X_DEV = 6'o05,
  parameter logic [DEV_W-1:0] Y_DEV = 6'o06
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_init,
  input  logic [WORD_W-1:0]  instr,
  input  logic               io_pulse1,
  input  logic               io_pulse2,
  input  logic               io_pulse3,
  input  logic [WORD_W-1:0]  acc,
  output logic [COORD_W-1:0] x_pos,
  output logic [COORD_W-1:0] y_pos,
  output logic               plot_req
);
  localparam int N_AXIS = 2;

  iot_ops_t           ops [N_AXIS];
  logic [N_AXIS-1:0]  hit;
  logic [N_AXIS-1:0]  plot_any;
  logic [COORD_W-1:0] pos [N_AXIS];

  for (genvar g = 0; g < N_AXIS; g++) begin : g_axis
    localparam logic [DEV_W-1:0] CODE = (g == 0) ? X_DEV : Y_DEV;

    iot_dev_decode #(.DEV_CODE(CODE)) u_dec (
      .instr     (instr),
      .io_pulse1 (io_pulse1),
      .io_pulse2 (io_pulse2),
      .io_pulse3 (io_pulse3),
      .hit       (hit[g]),
      .ops       (ops[g])
    );

    coord_reg #(.W(COORD_W)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .init  (bus_init),
      .clr   (ops[g].clr),
      .ld    (ops[g].ld),
      .d     (acc[COORD_W-1:0]),
      .q     (pos[g])
    );

    assign plot_any[g] = ops[g].plot;
  end

  plot_strobe u_plot (
    .clk   (clk),
    .rst_n (rst_n),
    .init  (bus_init),
    .fire  (|plot_any),
    .req   (plot_req)
  );

  assign x_pos = pos[0];
  assign y_pos = pos[1];

  assert_xload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ops[0].ld && !ops[0].clr && !bus_init) |=>
      ({{(WORD_W-COORD_W){1'b0}}, x_pos} == ($past(acc) & {{(WORD_W-COORD_W){1'b0}}, {COORD_W{1'b1}}})));
  assert_plot_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    plot_req |-> ($past(io_pulse3) && $past(instr[2]) && !$past(bus_init)));
  assert_foreign_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == '0 && !bus_init) |=> ($stable(x_pos) && $stable(y_pos) && !plot_req));
  assert_onehot_dev_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
endmodule

// File: tb/iot_xy_plot_tb.sv
module iot_xy_plot_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_init = 1'b0;
  logic [11:0] instr = '0;
  logic        io_pulse1 = 1'b0, io_pulse2 = 1'b0, io_pulse3 = 1'b0;
  logic [11:0] acc = '0;
  logic [9:0]  x_pos, y_pos;
  logic        plot_req;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [9:0] ex = '0, ey = '0;

  always #2 clk = ~clk;

  iot_xy_plot u_dut (
    .clk(clk), .rst_n(rst_n), .bus_init(bus_init), .instr(instr),
    .io_pulse1(io_pulse1), .io_pulse2(io_pulse2), .io_pulse3(io_pulse3),
    .acc(acc), .x_pos(x_pos), .y_pos(y_pos), .plot_req(plot_req)
  );

  function automatic bit accepted(input logic [11:0] w);
    return (w[11:9] == 3'o6) && (w[8:3] == 6'o05 || w[8:3] == 6'o06);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input bit exp_plot);
    chk({req, " x_pos"}, int'(x_pos), int'(ex));
    chk({req, " y_pos"}, int'(y_pos), int'(ey));
    chk({req, " plot_req"}, int'(plot_req), int'(exp_plot));
  endtask

  // Drives one instruction through its three pulses, checking after each.
  task automatic run_iot(input logic [11:0] w, input logic [11:0] a, input string req);
    bit hx, hy, pl;
    instr = w; acc = a;
    hx = accepted(w) && w[8:3] == 6'o05;
    hy = accepted(w) && w[8:3] == 6'o06;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      io_pulse1 = (k == 0); io_pulse2 = (k == 1); io_pulse3 = (k == 2);
      @(negedge clk);
      io_pulse1 = 0; io_pulse2 = 0; io_pulse3 = 0;
      pl = 0;
      if (k == 0 && w[0]) begin if (hx) ex = '0; if (hy) ey = '0; end
      if (k == 1 && w[1]) begin if (hx) ex = a[9:0]; if (hy) ey = a[9:0]; end
      if (k == 2 && w[2] && (hx || hy)) pl = 1;
      chk_all(req, pl);
      @(negedge clk);
      chk({req, " R4 plot_req one cycle"}, int'(plot_req), 0);
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [11:0] w;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk_all("R1 reset", 0);
    rst_n = 1;

    // R3, R10: load X with high acc bits set
    run_iot(12'o6052, 12'o7777, "R3 R10 load X");
    run_iot(12'o6062, 12'o6123, "R3 R10 load Y");
    // R2: clear X only, Y held (R9)
    run_iot(12'o6051, 12'o0000, "R2 R9 clear X");
    // R5: 6066 loads Y then plots
    run_iot(12'o6066, 12'o0555, "R5 load Y and plot");
    run_iot(12'o6054, 12'o1111, "R4 plot from X dev");
    run_iot(12'o6057, 12'o0321, "R5 clear load plot X");
    // R8: foreign device and foreign opcode
    run_iot(12'o6077, 12'o0777, "R8 foreign device");
    run_iot(12'o5067, 12'o0777, "R8 foreign opcode");

    // R6: clear and load on the same edge
    @(negedge clk);
    instr = 12'o6063; acc = 12'o0444; io_pulse1 = 1; io_pulse2 = 1;
    @(negedge clk);
    io_pulse1 = 0; io_pulse2 = 0; ey = '0;
    chk_all("R6 clear beats load", 0);

    // R7: init overrides a load and a plot
    run_iot(12'o6052, 12'o0246, "R3 reload X");
    @(negedge clk);
    instr = 12'o6066; acc = 12'o0100; io_pulse2 = 1; io_pulse3 = 1; bus_init = 1;
    @(negedge clk);
    io_pulse2 = 0; io_pulse3 = 0; bus_init = 0; ex = '0; ey = '0;
    chk_all("R7 init", 0);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      w = 12'($urandom);
      case ($urandom % 4)
        0: w[11:3] = {3'o6, 6'o05};
        1: w[11:3] = {3'o6, 6'o06};
        2: w[11:9] = 3'o6;
        default: ;
      endcase
      run_iot(w, 12'($urandom), "R5 R8 R9 random");
      if ($urandom % 25 == 0) begin
        @(negedge clk); bus_init = 1;
        @(negedge clk); bus_init = 0; ex = '0; ey = '0;
        chk_all("R7 random init", 0);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule